// File: doc/BRIEF.md
# Flash Write-Enable Key Sequencer

This block stands between software and a flash controller and decides whether one program or erase operation may proceed. Software writes an 8-bit key register through a strobe-and-data port. Two specific values written back to back open the block for exactly one operation. When the controller reports that the operation has finished, the block closes again on its own. Any misuse moves the block into a barred state that only reset clears. Misuse means a wrong key, a key written out of turn, or an operation requested while the block is closed. Software can also enter the barred state on purpose by writing any non-first key from the closed state.

The state machine has five states. LOCKED is the reset state. HALF means the first key has been seen. ARMED means the key pair is complete and no operation has been granted yet. FLIGHT means an operation has been granted and is running. BARRED means the block stays shut until reset.

The transitions are:
- LOCKED to HALF on a first-key write.
- HALF to ARMED on a second-key write.
- ARMED to FLIGHT on an accepted request.
- FLIGHT to LOCKED on a completion pulse.
- Any state to BARRED on a wrong or out-of-turn key write, or on a request in LOCKED or HALF.

BARRED has no exit. The readback port reports a 2-bit code: LOCKED gives 00, HALF gives 01, ARMED and FLIGHT both give 10, and BARRED gives 11.

Top module: `flash_key_guard`

## Requirements
- R1: After reset, rd_data is 0x00, op_grant is 0 and lockout is 0.
- R2: From LOCKED, a key write of 0xA5 gives code 01 on the following cycle. A further key write of 0xF1 then gives code 10 on the cycle after it.
- R3: op_grant is high in the same cycle as op_req only in ARMED with no key write in that cycle. The code stays 10 while the granted operation runs.
- R4: An op_done pulse in FLIGHT (with no key write) gives code 00 on the next cycle. Another operation then needs a fresh key pair.
- R5: An op_req in FLIGHT is not granted and does not change the state.
- R6: In LOCKED, a key write of any value other than 0xA5 gives code 11.
- R7: In HALF, a key write of any value other than 0xF1, including a repeat of 0xA5, gives code 11.
- R8: A key write in ARMED or FLIGHT gives code 11. In ARMED it also blocks a grant for a request in the same cycle.
- R9: An op_req in LOCKED or HALF is not granted and gives code 11, even when a correct key is written in the same cycle.
- R10: In BARRED, key writes, requests and completions are ignored. op_grant stays 0 and the code stays 11 until reset.
- R11: rd_data bits 7:2 always read 0, and lockout is 1 exactly when the code is 11.
- R12: An op_done pulse outside FLIGHT is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr | input | 1 | Key register write strobe |
| key_wdata | input | 8 | Key register write data |
| op_req | input | 1 | Flash program/erase request pulse |
| op_done | input | 1 | Completion pulse from the flash controller |
| op_grant | output | 1 | Request accepted (same cycle as op_req) |
| lockout | output | 1 | Sticky barred flag |
| rd_data | output | 8 | Key register readback, state code in bits 1:0 |

## Verification
The assertions check several rules on every cycle:
- BARRED never releases.
- A grant appears only with a request while the code reads 10.
- Nothing is granted while an operation is running.
- The upper readback bits stay zero and the lockout flag agrees with code 11.
- A completion closes the block, and a wrong first key or an early request bars it.

Only the bench scenarios can show the full sequences: a correct key pair leads to exactly one grant, a second operation needs a fresh key pair, and each misuse path, such as a repeated first key or a key written while an operation runs, ends in BARRED and stays there.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef enum logic [2:0] {
        FK_LOCKED = 3'd0,
        FK_HALF   = 3'd1,
        FK_ARMED  = 3'd2,
        FK_FLIGHT = 3'd3,
        FK_BARRED = 3'd4
    } fk_state_t;

    localparam int CODE_W = 2;

    localparam logic [CODE_W-1:0] CODE_LOCKED = 2'b00;
    localparam logic [CODE_W-1:0] CODE_HALF   = 2'b01;
    localparam logic [CODE_W-1:0] CODE_OPEN   = 2'b10;
    localparam logic [CODE_W-1:0] CODE_BARRED = 2'b11;

    function automatic logic [CODE_W-1:0] code_of(input fk_state_t s);
        logic [CODE_W-1:0] c;
        unique case (s)
            FK_LOCKED: c = CODE_LOCKED;
            FK_HALF:   c = CODE_HALF;
            FK_ARMED:  c = CODE_OPEN;
            FK_FLIGHT: c = CODE_OPEN;
            FK_BARRED: c = CODE_BARRED;
            default:   c = CODE_BARRED;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/flk_key_cmp.sv
module flk_key_cmp #(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hA5,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hF1
) (
    input  logic [DATA_W-1:0] wdata,
    output logic              is_first,
    output logic              is_second
);

    always_comb begin
        is_first  = (wdata == KEY_FIRST);
        is_second = (wdata == KEY_SECOND);
    end

endmodule

// File: rtl/flk_fsm.sv
module flk_fsm
    import flk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      key_wr,
    input  logic      is_first,
    input  logic      is_second,
    input  logic      op_req,
    input  logic      op_done,
    output fk_state_t state,
    output logic      grant
);

    fk_state_t state_q;
    fk_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FK_LOCKED: begin
                if (op_req) begin
                    state_d = FK_BARRED;
                end else if (key_wr) begin
                    state_d = is_first ? FK_HALF : FK_BARRED;
                end
            end
            FK_HALF: begin
                if (op_req) begin
                    state_d = FK_BARRED;
                end else if (key_wr) begin
                    state_d = is_second ? FK_ARMED : FK_BARRED;
                end
            end
            FK_ARMED: begin
                if (key_wr) begin
                    state_d = FK_BARRED;
                end else if (op_req) begin
                    state_d = FK_FLIGHT;
                end
            end
            FK_FLIGHT: begin
                if (key_wr) begin
                    state_d = FK_BARRED;
                end else if (op_done) begin
                    state_d = FK_LOCKED;
                end
            end
            FK_BARRED: begin
                state_d = FK_BARRED;
            end
            default: begin
                state_d = FK_BARRED;
            end
        endcase
    end

    // outputs
    always_comb begin
        state = state_q;
        grant = 1'b0;
        unique case (state_q)
            FK_ARMED:  grant = op_req && !key_wr;
            FK_LOCKED,
            FK_HALF,
            FK_FLIGHT,
            FK_BARRED: grant = 1'b0;
            default:   grant = 1'b0;
        endcase
    end

endmodule

// File: rtl/flk_readback.sv
module flk_readback
    import flk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  fk_state_t         state,
    output logic [DATA_W-1:0] rd_data,
    output logic              lockout
);

    logic [CODE_W-1:0] code;

    always_comb begin
        code    = code_of(state);
        lockout = (state == FK_BARRED);
    end

    generate
        if (DATA_W > CODE_W) begin : g_pad
            assign rd_data = {{(DATA_W-CODE_W){1'b0}}, code};
        end else begin : g_nopad
            assign rd_data = code[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/flash_key_guard.sv
module flash_key_guard
    import flk_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hA5,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hF1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_wdata,
    input  logic              op_req,
    input  logic              op_done,
    output logic              op_grant,
    output logic              lockout,
    output logic [DATA_W-1:0] rd_data
);

    logic      is_first;
    logic      is_second;
    fk_state_t state;

    flk_key_cmp #(
        .DATA_W    (DATA_W),
        .KEY_FIRST (KEY_FIRST),
        .KEY_SECOND(KEY_SECOND)
    ) u_cmp (
        .wdata    (key_wdata),
        .is_first (is_first),
        .is_second(is_second)
    );

    flk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .is_first (is_first),
        .is_second(is_second),
        .op_req   (op_req),
        .op_done  (op_done),
        .state    (state),
        .grant    (op_grant)
    );

    flk_readback #(
        .DATA_W(DATA_W)
    ) u_rb (
        .state  (state),
        .rd_data(rd_data),
        .lockout(lockout)
    );

endmodule

// File: rtl/flash_key_guard_chk.sv
module flash_key_guard_chk #(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hA5,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hF1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_wr,
    input logic [DATA_W-1:0] key_wdata,
    input logic              op_req,
    input logic              op_done,
    input logic              op_grant,
    input logic              lockout,
    input logic [DATA_W-1:0] rd_data
);

    logic in_flight;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_flight <= 1'b0;
        end else if (op_grant) begin
            in_flight <= 1'b1;
        end else if (op_done || key_wr) begin
            in_flight <= 1'b0;
        end
    end

    // R10
    barred_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> lockout);

    // R3
    grant_only_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_grant |-> (op_req && !key_wr && rd_data[1:0] == 2'b10 && !in_flight));

    // R5
    no_second_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight && op_req) |-> !op_grant);

    // R4
    done_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight && op_done && !key_wr) |=> (rd_data[1:0] == 2'b00));

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DATA_W-1:2] == '0) && (lockout == (rd_data[1:0] == 2'b11)));

    // R6
    bad_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] == 2'b00 && key_wr && key_wdata != KEY_FIRST) |=> lockout);

    // R9
    early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] == 1'b0 && op_req) |-> (!op_grant ##1 lockout));

    // R7
    bad_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] == 2'b01 && key_wr && key_wdata != KEY_SECOND) |=> lockout);

endmodule

bind flash_key_guard flash_key_guard_chk #(
    .DATA_W    (DATA_W),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_wdata(key_wdata),
    .op_req   (op_req),
    .op_done  (op_done),
    .op_grant (op_grant),
    .lockout  (lockout),
    .rd_data  (rd_data)
);

// File: tb/flash_key_guard_tb.sv
module flash_key_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_wr = 1'b0;
    logic [7:0] key_wdata = 8'h00;
    logic       op_req = 1'b0;
    logic       op_done = 1'b0;
    logic       op_grant;
    logic       lockout;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    flash_key_guard u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_wdata(key_wdata),
        .op_req   (op_req),
        .op_done  (op_done),
        .op_grant (op_grant),
        .lockout  (lockout),
        .rd_data  (rd_data)
    );

    // row: {req_tag[3:0], key_wr, data[7:0], op_req, op_done, exp_grant, exp_code[1:0]}
    localparam int NV = 14;
    localparam logic [17:0] VEC [0:NV-1] = '{
        {4'd2,  1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b01}, // R2 first key
        {4'd2,  1'b1, 8'hF1, 1'b0, 1'b0, 1'b0, 2'b10}, // R2 second key
        {4'd3,  1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 2'b10}, // R3 accepted request
        {4'd5,  1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b10}, // R5 request while running
        {4'd3,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10}, // R3 still open while running
        {4'd4,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00}, // R4 completion relocks
        {4'd12, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00}, // R12 stray completion
        {4'd2,  1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b01}, // R2 fresh first key
        {4'd2,  1'b1, 8'hF1, 1'b0, 1'b0, 1'b0, 2'b10}, // R2 fresh second key
        {4'd12, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 2'b10}, // R12 done ignored in ARMED
        {4'd4,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00}, // R4 second relock
        {4'd6,  1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 2'b11}, // R6 wrong first key
        {4'd10, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b11}, // R10 key ignored when barred
        {4'd10, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 2'b11}  // R10 request ignored when barred
    };

    task automatic check_code(input int req, input logic [1:0] exp);
        checks++;
        if (rd_data !== {6'b0, exp} || lockout !== (exp == 2'b11)) begin
            fails++;
            $display("FAIL R%0d: rd_data=%02h lockout=%b expected rd_data=%02h lockout=%b",
                     req, rd_data, lockout, {6'b0, exp}, (exp == 2'b11));
        end
    endtask

    task automatic check_grant(input int req, input logic exp);
        checks++;
        if (op_grant !== exp) begin
            fails++;
            $display("FAIL R%0d: op_grant=%b expected %b", req, op_grant, exp);
        end
    endtask

    task automatic step(input int req, input logic kw, input logic [7:0] d,
                        input logic rq, input logic dn,
                        input logic eg, input logic [1:0] ecode);
        @(negedge clk);
        key_wr = kw; key_wdata = d; op_req = rq; op_done = dn;
        #1;
        check_grant(req, eg);
        @(posedge clk);
        #1;
        key_wr = 1'b0; op_req = 1'b0; op_done = 1'b0;
        check_code(req, ecode);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; key_wr = 1'b0; op_req = 1'b0; op_done = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        #1;
        check_code(1, 2'b00);
        check_grant(1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(int'(VEC[i][17:14]), VEC[i][13], VEC[i][12:5], VEC[i][4],
                 VEC[i][3], VEC[i][2], VEC[i][1:0]);
        end

        // R7 wrong second key
        do_reset();
        step(2, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b01);
        step(7, 1'b1, 8'h12, 1'b0, 1'b0, 1'b0, 2'b11);
        // R7 repeated first key
        do_reset();
        step(2, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b01);
        step(7, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b11);
        // R8 key write in ARMED
        do_reset();
        step(2, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b01);
        step(2, 1'b1, 8'hF1, 1'b0, 1'b0, 1'b0, 2'b10);
        step(8, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b11);
        // R8 key write with request in ARMED: no grant
        do_reset();
        step(2, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b01);
        step(2, 1'b1, 8'hF1, 1'b0, 1'b0, 1'b0, 2'b10);
        step(8, 1'b1, 8'hF1, 1'b1, 1'b0, 1'b0, 2'b11);
        // R8 key write in FLIGHT, even with completion
        do_reset();
        step(2, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b01);
        step(2, 1'b1, 8'hF1, 1'b0, 1'b0, 1'b0, 2'b10);
        step(3, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 2'b10);
        step(8, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 2'b11);
        // R9 request in LOCKED with correct first key
        do_reset();
        step(9, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 2'b11);
        // R9 request in HALF
        do_reset();
        step(2, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 2'b01);
        step(9, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b11);
        // R10 barred persists over idle cycles, cleared only by reset
        repeat (5) @(posedge clk);
        #1;
        check_code(10, 2'b11);
        do_reset();
        #1;
        check_code(1, 2'b00);

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule